// File: doc/BRIEF.md
# Three-Phase Trip Relay Controller

This block drives one relay-energize output per phase (A, B, C) from active-low trip request lines. Each request is filtered by a debounce window of half a millisecond to one millisecond before it can act. In single-pole operation each phase follows its own request. In three-pole operation a request on any phase energizes all three outputs together. A global disable input blocks every output.

Once a request goes away, the output is released in one of three ways, chosen by configuration. Current-gated release keeps the relay closed until that phase's current-sense flag also clears. Immediate release opens it at once. Delayed release opens it after a programmable number of milliseconds. A separate download block supplies the configuration as a one-cycle load strobe that carries the pole mode and the release code. Until the first valid load has been taken, every output stays off and the disable indicator stays lit.

Time comes from an internal divider set by the number of clock cycles per millisecond. The divider gives a half-millisecond tick for the debounce and a one-millisecond tick for the release delay.

Top module: `trip_relay_ctrl`

## Requirements
- R1: Bit i of `tripReqN`, `senseCur` and `relayOn` belongs to phase i (0=A, 1=B, 2=C). A request line at 0 asks for a trip, and a line at 1 is idle.
- R2: In single-pole mode (`cfgThreePole`=0), a debounced request on one phase energizes only that phase's output.
- R3: In three-pole mode (`cfgThreePole`=1), a debounced request on any phase energizes all three outputs.
- R4: A change on a request line reaches the output only after it has held for two half-millisecond ticks (0.5 to 1 ms). A pulse shorter than one tick period has no effect on `relayOn`.
- R5: While `tripDisable` is 1, all outputs are 0 from the first clock edge after it rises, and `disableLed` is 1.
- R6: With release code 2 (immediate), an output drops one cycle after its debounced request is gone.
- R7: With release code 1 (current-gated), an output stays energized after its request is gone for as long as that phase's `senseCur` is 1. It drops on the clock after `senseCur` falls.
- R8: With release code 3 (delayed), an output drops REL_DELAY_MS millisecond ticks after its debounced request is gone. This gives a hold time of between REL_DELAY_MS-1 and REL_DELAY_MS ms.
- R9: If a request returns during the delayed-release wait, the wait is cancelled and the output stays energized.
- R10: After reset, outputs stay 0 and `disableLed` stays 1 until a load strobe (`cfgValid`=1) arrives with a nonzero release code. A load with code 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tripReqN | input | 3 | Per-phase trip request, active low |
| senseCur | input | 3 | Per-phase coil current above release level |
| tripDisable | input | 1 | Global trip block, active high |
| cfgValid | input | 1 | One-cycle configuration load strobe |
| cfgThreePole | input | 1 | 1 = three-pole fan-out, 0 = single-pole |
| cfgRelMode | input | 2 | Release code: 1 current, 2 immediate, 3 delayed, 0 invalid |
| relayOn | output | 3 | Per-phase relay energize |
| disableLed | output | 1 | Block disabled (unloaded or tripDisable) |

## Verification
Every fault in the phase state machines shows up directly on `relayOn`. A wrong state either holds a relay that should have opened or drops one that should stay closed. The bench catches this within one cycle of the expected drop for immediate and current-gated release, and within one millisecond tick for delayed release. A debounce counter that is off by one changes when a request first appears by half a millisecond, and it lets a short glitch through. Sampling points placed just inside and just outside each timing window expose both faults. Configuration errors, such as a lost load, a load with code 0 taken as valid, or the wrong pole mode, show up on the first trip after the load, either as the wrong set of energized phases or as `disableLed` left at the wrong level.

// File: rtl/trip_pkg.sv
package trip_pkg;
  localparam int NUM_PH = 3;

  typedef enum logic [1:0] {
    REL_NONE      = 2'd0,
    REL_CURRENT   = 2'd1,
    REL_IMMEDIATE = 2'd2,
    REL_DELAYED   = 2'd3
  } rel_mode_e;

  typedef enum logic [1:0] {
    PH_OFF,
    PH_ON,
    PH_WAIT_CUR,
    PH_DELAY
  } phase_st_e;

  typedef struct packed {
    logic [NUM_PH-1:0] delayLoad;
    logic [NUM_PH-1:0] delayRun;
  } trip_strobe_t;
endpackage

// File: rtl/trip_datapath.sv
module trip_datapath
  import trip_pkg::*;
#(
  parameter int CYC_PER_MS   = 100000,
  parameter int REL_DELAY_MS = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_PH-1:0] tripReqN,
  input  trip_strobe_t      strobe,
  output logic [NUM_PH-1:0] tripAct,
  output logic [NUM_PH-1:0] delayDone
);
  localparam int HALF_CYC = CYC_PER_MS / 2;
  localparam int DIV_W    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int DLY_W    = $clog2(REL_DELAY_MS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYC - 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(REL_DELAY_MS - 1);

  logic [DIV_W-1:0] divCnt;
  logic             halfTick;
  logic             msPhase;
  logic             msTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      msPhase <= 1'b0;
    end else if (divCnt == DIV_LAST) begin
      divCnt  <= '0;
      msPhase <= ~msPhase;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign halfTick = (divCnt == DIV_LAST);
  assign msTick   = halfTick && msPhase;

  logic [NUM_PH-1:0] rawQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawQ <= '0;
    else       rawQ <= ~tripReqN;
  end

  for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
    logic             bounceCnt;
    logic [DLY_W-1:0] dlyCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tripAct[p] <= 1'b0;
        bounceCnt  <= 1'b0;
      end else if (halfTick) begin
        if (rawQ[p] != tripAct[p]) begin
          if (bounceCnt) begin
            tripAct[p] <= rawQ[p];
            bounceCnt  <= 1'b0;
          end else begin
            bounceCnt <= 1'b1;
          end
        end else begin
          bounceCnt <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    dlyCnt <= '0;
      else if (strobe.delayLoad[p]) dlyCnt <= '0;
      else if (strobe.delayRun[p] && msTick && dlyCnt != DLY_LAST)
        dlyCnt <= dlyCnt + 1'b1;
    end

    assign delayDone[p] = strobe.delayRun[p] && msTick && (dlyCnt == DLY_LAST);

    a_r4_change_on_tick: assert property (@(posedge clk) disable iff (!rstN)
      !halfTick |=> $stable(tripAct[p]))
      else $error("R4: debounced request moved off a tick");

    a_r8_delay_in_range: assert property (@(posedge clk) disable iff (!rstN)
      dlyCnt <= DLY_LAST)
      else $error("R8: delay counter beyond limit");
  end
endmodule

// File: rtl/trip_control.sv
module trip_control
  import trip_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_PH-1:0] tripAct,
  input  logic [NUM_PH-1:0] senseCur,
  input  logic [NUM_PH-1:0] delayDone,
  input  logic              tripDisable,
  input  logic              cfgValid,
  input  logic              cfgThreePole,
  input  logic [1:0]        cfgRelMode,
  output trip_strobe_t      strobe,
  output logic [NUM_PH-1:0] relayOn,
  output logic              disableLed
);
  logic      cfgLoaded;
  logic      threePole;
  rel_mode_e relMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgLoaded <= 1'b0;
      threePole <= 1'b0;
      relMode   <= REL_NONE;
    end else if (cfgValid && cfgRelMode != 2'd0) begin
      cfgLoaded <= 1'b1;
      threePole <= cfgThreePole;
      relMode   <= rel_mode_e'(cfgRelMode);
    end
  end

  logic              blocked;
  logic [NUM_PH-1:0] req;

  assign blocked    = !cfgLoaded || tripDisable;
  assign disableLed = blocked;
  assign req        = threePole ? {NUM_PH{|tripAct}} : tripAct;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_phase
    phase_st_e stQ, stD;

    always_comb begin
      stD                = stQ;
      strobe.delayLoad[p] = 1'b0;
      strobe.delayRun[p]  = (stQ == PH_DELAY);
      if (blocked) begin
        stD = PH_OFF;
      end else begin
        unique case (stQ)
          PH_OFF: if (req[p]) stD = PH_ON;
          PH_ON: if (!req[p]) begin
            unique case (relMode)
              REL_CURRENT:  stD = senseCur[p] ? PH_WAIT_CUR : PH_OFF;
              REL_DELAYED: begin
                stD                 = PH_DELAY;
                strobe.delayLoad[p] = 1'b1;
              end
              default:      stD = PH_OFF;
            endcase
          end
          PH_WAIT_CUR: begin
            if (req[p])           stD = PH_ON;
            else if (!senseCur[p]) stD = PH_OFF;
          end
          PH_DELAY: begin
            if (req[p])            stD = PH_ON;
            else if (delayDone[p]) stD = PH_OFF;
          end
          default: stD = PH_OFF;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stQ <= PH_OFF;
      else       stQ <= stD;
    end

    assign relayOn[p] = (stQ != PH_OFF);

    a_r5_disable_drops: assert property (@(posedge clk) disable iff (!rstN)
      tripDisable |=> !relayOn[p])
      else $error("R5: output on after disable");

    a_r10_unloaded_off: assert property (@(posedge clk) disable iff (!rstN)
      !cfgLoaded |-> !relayOn[p])
      else $error("R10: output on before load");

    a_r6_immediate_drop: assert property (@(posedge clk) disable iff (!rstN)
      (relMode == REL_IMMEDIATE && stQ == PH_ON && !req[p]) |=> !relayOn[p])
      else $error("R6: immediate release late");

    a_r7_hold_on_current: assert property (@(posedge clk) disable iff (!rstN)
      (relMode == REL_CURRENT && relayOn[p] && senseCur[p] && !blocked) |=> relayOn[p])
      else $error("R7: dropped with current");

    a_r9_cancel_delay: assert property (@(posedge clk) disable iff (!rstN)
      (stQ == PH_DELAY && req[p] && !blocked) |=> relayOn[p])
      else $error("R9: delay not cancelled");
  end

  a_r3_fan_out: assert property (@(posedge clk) disable iff (!rstN)
    (threePole && !blocked && |tripAct) |=> &relayOn)
    else $error("R3: three-pole fan-out missing");
endmodule

// File: rtl/trip_relay_ctrl.sv
module trip_relay_ctrl
  import trip_pkg::*;
#(
  parameter int CYC_PER_MS   = 100000,
  parameter int REL_DELAY_MS = 100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] tripReqN,
  input  logic [2:0] senseCur,
  input  logic       tripDisable,
  input  logic       cfgValid,
  input  logic       cfgThreePole,
  input  logic [1:0] cfgRelMode,
  output logic [2:0] relayOn,
  output logic       disableLed
);
  trip_strobe_t      strobe;
  logic [NUM_PH-1:0] tripAct;
  logic [NUM_PH-1:0] delayDone;

  trip_datapath #(
    .CYC_PER_MS  (CYC_PER_MS),
    .REL_DELAY_MS(REL_DELAY_MS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tripReqN (tripReqN),
    .strobe   (strobe),
    .tripAct  (tripAct),
    .delayDone(delayDone)
  );

  trip_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tripAct     (tripAct),
    .senseCur    (senseCur),
    .delayDone   (delayDone),
    .tripDisable (tripDisable),
    .cfgValid    (cfgValid),
    .cfgThreePole(cfgThreePole),
    .cfgRelMode  (cfgRelMode),
    .strobe      (strobe),
    .relayOn     (relayOn),
    .disableLed  (disableLed)
  );
endmodule

// File: tb/tb_trip_relay_ctrl.sv
module tb_trip_relay_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] tripReqN = 3'b111;
  logic [2:0] senseCur = 3'b000;
  logic       tripDisable = 1'b0;
  logic       cfgValid = 1'b0;
  logic       cfgThreePole = 1'b0;
  logic [1:0] cfgRelMode = 2'd0;
  logic [2:0] relayOn;
  logic       disableLed;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  trip_relay_ctrl #(.CYC_PER_MS(20), .REL_DELAY_MS(5)) dut (
    .clk(clk), .rstN(rstN), .tripReqN(tripReqN), .senseCur(senseCur),
    .tripDisable(tripDisable), .cfgValid(cfgValid), .cfgThreePole(cfgThreePole),
    .cfgRelMode(cfgRelMode), .relayOn(relayOn), .disableLed(disableLed)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load(input logic three, input logic [1:0] code);
    cfgThreePole = three;
    cfgRelMode   = code;
    cfgValid     = 1'b1;
    waitCyc(1);
    cfgValid     = 1'b0;
    waitCyc(2);
  endtask

  task automatic t_reset;
    check("R10 reset relays", relayOn, 3'b000);
    check("R10 reset led", {2'b0, disableLed}, 3'b001);
  endtask

  task automatic t_preload;
    load(1'b0, 2'd0);
    tripReqN = 3'b110;
    waitCyc(40);
    check("R10 code0 ignored relays", relayOn, 3'b000);
    check("R10 code0 ignored led", {2'b0, disableLed}, 3'b001);
    tripReqN = 3'b111;
    waitCyc(40);
  endtask

  task automatic t_single_immediate;
    load(1'b0, 2'd2);
    check("R10 led after load", {2'b0, disableLed}, 3'b000);
    tripReqN = 3'b101;
    waitCyc(30);
    check("R2 R1 phase B only", relayOn, 3'b010);
    tripReqN = 3'b111;
    waitCyc(8);
    check("R4 release not yet debounced", relayOn, 3'b010);
    waitCyc(22);
    check("R6 immediate release", relayOn, 3'b000);
  endtask

  task automatic t_glitch;
    tripReqN = 3'b110;
    waitCyc(3);
    tripReqN = 3'b111;
    waitCyc(40);
    check("R4 short glitch ignored", relayOn, 3'b000);
  endtask

  task automatic t_three_pole;
    load(1'b1, 2'd2);
    tripReqN = 3'b011;
    waitCyc(30);
    check("R3 fan-out from C", relayOn, 3'b111);
    tripReqN = 3'b111;
    waitCyc(30);
    check("R3 fan-out release", relayOn, 3'b000);
  endtask

  task automatic t_disable;
    load(1'b0, 2'd2);
    tripReqN = 3'b110;
    waitCyc(30);
    check("R2 phase A on", relayOn, 3'b001);
    tripDisable = 1'b1;
    waitCyc(1);
    check("R5 disable next clock", relayOn, 3'b000);
    check("R5 disable led", {2'b0, disableLed}, 3'b001);
    waitCyc(10);
    check("R5 stays off", relayOn, 3'b000);
    tripDisable = 1'b0;
    waitCyc(2);
    check("R5 resume after disable", relayOn, 3'b001);
    tripReqN = 3'b111;
    waitCyc(30);
  endtask

  task automatic t_current;
    load(1'b0, 2'd1);
    senseCur = 3'b001;
    tripReqN = 3'b110;
    waitCyc(30);
    check("R7 trip on", relayOn, 3'b001);
    tripReqN = 3'b111;
    waitCyc(40);
    check("R7 held by current", relayOn, 3'b001);
    senseCur = 3'b000;
    waitCyc(2);
    check("R7 drop on current off", relayOn, 3'b000);
    tripReqN = 3'b101;
    waitCyc(30);
    tripReqN = 3'b111;
    waitCyc(30);
    check("R7 no current quick release", relayOn, 3'b000);
  endtask

  task automatic t_delayed;
    load(1'b0, 2'd3);
    tripReqN = 3'b110;
    waitCyc(30);
    check("R8 trip on", relayOn, 3'b001);
    tripReqN = 3'b111;
    waitCyc(85);
    check("R8 still held in delay", relayOn, 3'b001);
    waitCyc(50);
    check("R8 dropped after delay", relayOn, 3'b000);
    tripReqN = 3'b110;
    waitCyc(30);
    tripReqN = 3'b111;
    waitCyc(50);
    tripReqN = 3'b110;
    waitCyc(150);
    check("R9 delay cancelled", relayOn, 3'b001);
    tripReqN = 3'b111;
    waitCyc(150);
    check("R9 later release", relayOn, 3'b000);
  endtask

  initial begin
    waitCyc(3);
    t_reset();
    rstN = 1'b1;
    waitCyc(2);
    t_preload();
    t_single_immediate();
    t_glitch();
    t_three_pole();
    t_disable();
    t_current();
    t_delayed();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule